// File: doc/BRIEF.md
# Write-Protect Register and Acknowledge Policy

This block sits beside the serial front end of a 256-byte nonvolatile memory. It holds the software protection state for the lower half of the array and, for each phase of a transaction, decides whether the device acknowledges. Those phases are the command byte, the word-address byte and the data byte. It also tells the write-cycle unit whether the current write may be committed. The front end supplies the device-type nibble, the 3-bit field that follows it, the read/write bit, the word address, the level of the hardware write-protect pin and the current phase. The block returns one acknowledge enable per phase, the acknowledge for the phase now in progress, and a commit-allowed flag.

There are two protection flags. The reversible flag can be set and cleared by command. The permanent flag can be set once and never cleared. Both flags stand in for nonvolatile cells, so reset leaves them alone and they start from parameter values. A protect command only takes effect when the write-cycle unit signals that its programming time has ended. Until then the command is held as a pending operation. Reset discards a pending operation.

Top module: `wp_guard`

## Requirements
- R1: Command decode works as follows. Type 4'b0110 selects a protect command. Within it, field 3'b001 is "set reversible" and field 3'b011 is "clear reversible". Any other field equal to the strap pins is "set permanent". A protect command with any other field, a memory access (type 4'b1010) whose field differs from the strap pins, and any other type all leave every acknowledge and the commit flag low.
- R2: With no protection and the pin low, memory writes and all three write-form protect commands are acknowledged on the command, address and data phases, and commit is allowed.
- R3: With the pin high, a memory write at any address gets acknowledges on command and address, no acknowledge on data, and no commit. A write-form protect command that the current state does not refuse gets the same pattern.
- R4: In the reversible state, "set reversible" is refused on every phase. A memory write below address 8'h80 gets no acknowledge on data and no commit. A write at 8'h80 or above with the pin low is accepted in full.
- R5: In the permanent state, every protect command, in either read or write form, is refused on every phase. A memory write below 8'h80 gets no acknowledge on data and no commit.
- R6: Read-form commands never acknowledge the address or data phase and never allow commit. A read-form protect command acknowledges its command byte exactly when the state would not refuse it. A memory read acknowledges its command byte.
- R7: A protect command that is accepted on its data phase (phase 2'b11) becomes pending. Its effect appears only after the clock edge that samples the write-cycle done pulse. "Set reversible" sets the reversible flag, "clear reversible" clears it, and "set permanent" sets the permanent flag.
- R8: Once set, the permanent flag never clears. A "clear reversible" command cannot undo it.
- R9: Reset leaves both protection flags unchanged and discards any pending operation.
- R10: The current-phase acknowledge equals the command, address or data enable for phases 2'b01, 2'b10 and 2'b11, and is low in the idle phase 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pending operation |
| dev_code | input | 4 | Device-type nibble of the slave address |
| dev_field | input | 3 | Field after the device type |
| strap | input | 3 | Strap-pin address of this device |
| rw | input | 1 | Read/write bit, 1 = read |
| word_addr | input | 8 | Word address of the transaction |
| wp_pin | input | 1 | Hardware write-protect level, 1 = protect all |
| phase | input | 2 | Transaction phase: 00 idle, 01 command, 10 address, 11 data |
| cyc_done | input | 1 | Pulse from the write-cycle unit: programming time over |
| ack_cmd | output | 1 | Acknowledge enable for the command byte |
| ack_addr | output | 1 | Acknowledge enable for the word-address byte |
| ack_data | output | 1 | Acknowledge enable for the data byte |
| ack_now | output | 1 | Acknowledge for the phase now in progress |
| commit_ok | output | 1 | The current write may be committed |

## Verification
If the reversible flag holds a wrong value, it shows up on the very next transaction. "Set reversible" is refused when it should be accepted, or the reverse, and a low-half memory write gains or loses its data acknowledge. Both outputs are purely combinational from the flag, so the error is visible in the same cycle the command is presented.

A wrong permanent flag shows up at once as acknowledges present or missing on protect commands. A lost or stray pending operation shows up only one edge after the done pulse, as a state change that did or did not happen. The bench therefore sweeps every command, pin level, direction and address half in each of the three states, and it probes the state both before and after each done pulse and across reset.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_CMD  = 2'b01,
    PH_ADDR = 2'b10,
    PH_DATA = 2'b11
  } phase_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_MEM_WR,
    K_MEM_RD,
    K_SET,
    K_CLR,
    K_PERM
  } kind_e;

  typedef struct packed {
    logic cmd;
    logic addr;
    logic data;
  } ack_s;

  // True for the three protect-register operations.
  function automatic logic is_prot_kind(kind_e k);
    return (k == K_SET) || (k == K_CLR) || (k == K_PERM);
  endfunction

  // Protect commands the current state refuses outright.
  function automatic logic refused(kind_e k, logic rev, logic perm);
    return is_prot_kind(k) && (perm || ((k == K_SET) && rev));
  endfunction

  // Phase-by-phase acknowledge matrix.
  function automatic ack_s policy(kind_e k, logic rw, logic lo_half,
                                  logic wp, logic rev, logic perm);
    ack_s a;
    a = '0;
    unique case (k)
      K_MEM_RD: a.cmd = 1'b1;
      K_MEM_WR: begin
        a.cmd  = 1'b1;
        a.addr = 1'b1;
        a.data = !wp && !(lo_half && (rev || perm));
      end
      K_SET, K_CLR, K_PERM: begin
        if (!refused(k, rev, perm)) begin
          a.cmd  = 1'b1;
          a.addr = !rw;
          a.data = !rw && !wp;
        end
      end
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_guard_pkg::*;
#(
  parameter int          CODE_W    = 4,
  parameter int          FIELD_W   = 3,
  parameter logic [3:0]  MEM_CODE  = 4'b1010,
  parameter logic [3:0]  PROT_CODE = 4'b0110,
  parameter logic [2:0]  SET_FIELD = 3'b001,
  parameter logic [2:0]  CLR_FIELD = 3'b011
) (
  input  logic [CODE_W-1:0]  dev_code,
  input  logic [FIELD_W-1:0] dev_field,
  input  logic [FIELD_W-1:0] strap,
  input  logic               rw,
  output kind_e              kind_o
);

  logic mem_hit;
  logic prot_hit;
  logic strap_hit;

  assign mem_hit   = (dev_code == CODE_W'(MEM_CODE));
  assign prot_hit  = (dev_code == CODE_W'(PROT_CODE));
  assign strap_hit = (dev_field == strap);

  always_comb begin
    kind_o = K_NONE;
    if (mem_hit && strap_hit) begin
      kind_o = rw ? K_MEM_RD : K_MEM_WR;
    end else if (prot_hit) begin
      if (dev_field == FIELD_W'(SET_FIELD))      kind_o = K_SET;
      else if (dev_field == FIELD_W'(CLR_FIELD)) kind_o = K_CLR;
      else if (strap_hit)                        kind_o = K_PERM;
      else                                       kind_o = K_NONE;
    end
  end

endmodule

// File: rtl/wp_ack_matrix.sv
module wp_ack_matrix
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  kind_e             kind,
  input  logic              rw,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              wp_pin,
  input  logic              rev,
  input  logic              perm,
  input  logic [1:0]        phase,
  output logic              ack_cmd,
  output logic              ack_addr,
  output logic              ack_data,
  output logic              ack_now,
  output logic              commit_ok
);

  localparam int TOP = ADDR_W - 1;

  logic lo_half;
  ack_s ack;

  assign lo_half = !word_addr[TOP];

  always_comb ack = policy(kind, rw, lo_half, wp_pin, rev, perm);

  assign ack_cmd   = ack.cmd;
  assign ack_addr  = ack.addr;
  assign ack_data  = ack.data;
  assign commit_ok = ack.data && !rw;

  always_comb begin
    unique case (phase_e'(phase))
      PH_CMD:  ack_now = ack.cmd;
      PH_ADDR: ack_now = ack.addr;
      PH_DATA: ack_now = ack.data;
      default: ack_now = 1'b0;
    endcase
  end

endmodule

// File: rtl/wp_flag_store.sv
module wp_flag_store
  import wp_guard_pkg::*;
#(
  parameter bit INIT_REV  = 1'b0,
  parameter bit INIT_PERM = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  kind_e cap_kind,
  input  logic  cyc_done,
  output logic  rev_o,
  output logic  perm_o,
  output logic  pend_o
);

  // Nonvolatile cells: start from stored values, untouched by reset.
  logic  rev_q  = INIT_REV;
  logic  perm_q = INIT_PERM;
  logic  pend_v;
  kind_e pend_k;
  logic  apply;

  assign apply = cyc_done && pend_v;

  always_ff @(posedge clk) begin
    if (apply) begin
      unique case (pend_k)
        K_SET:   rev_q  <= 1'b1;
        K_CLR:   rev_q  <= 1'b0;
        K_PERM:  perm_q <= 1'b1;
        default: rev_q  <= rev_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_k <= K_NONE;
    end else begin
      if (cyc_done) pend_v <= 1'b0;
      if (capture) begin
        pend_v <= 1'b1;
        pend_k <= cap_kind;
      end
    end
  end

  assign rev_o  = rev_q;
  assign perm_o = perm_q;
  assign pend_o = pend_v;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_guard_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          CODE_W    = 4,
  parameter int          FIELD_W   = 3,
  parameter logic [3:0]  MEM_CODE  = 4'b1010,
  parameter logic [3:0]  PROT_CODE = 4'b0110,
  parameter logic [2:0]  SET_FIELD = 3'b001,
  parameter logic [2:0]  CLR_FIELD = 3'b011,
  parameter bit          INIT_REV  = 1'b0,
  parameter bit          INIT_PERM = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  dev_code,
  input  logic [FIELD_W-1:0] dev_field,
  input  logic [FIELD_W-1:0] strap,
  input  logic               rw,
  input  logic [ADDR_W-1:0]  word_addr,
  input  logic               wp_pin,
  input  logic [1:0]         phase,
  input  logic               cyc_done,
  output logic               ack_cmd,
  output logic               ack_addr,
  output logic               ack_data,
  output logic               ack_now,
  output logic               commit_ok
);

  kind_e kind;
  logic  rev_flag;
  logic  perm_flag;
  logic  pend_flag;
  logic  prot_cmd;
  logic  capture;

  wp_cmd_decode #(
    .CODE_W(CODE_W), .FIELD_W(FIELD_W),
    .MEM_CODE(MEM_CODE), .PROT_CODE(PROT_CODE),
    .SET_FIELD(SET_FIELD), .CLR_FIELD(CLR_FIELD)
  ) u_dec (
    .dev_code (dev_code),
    .dev_field(dev_field),
    .strap    (strap),
    .rw       (rw),
    .kind_o   (kind)
  );

  wp_ack_matrix #(.ADDR_W(ADDR_W)) u_mtx (
    .kind     (kind),
    .rw       (rw),
    .word_addr(word_addr),
    .wp_pin   (wp_pin),
    .rev      (rev_flag),
    .perm     (perm_flag),
    .phase    (phase),
    .ack_cmd  (ack_cmd),
    .ack_addr (ack_addr),
    .ack_data (ack_data),
    .ack_now  (ack_now),
    .commit_ok(commit_ok)
  );

  assign prot_cmd = is_prot_kind(kind);
  assign capture  = prot_cmd && commit_ok && (phase_e'(phase) == PH_DATA);

  wp_flag_store #(.INIT_REV(INIT_REV), .INIT_PERM(INIT_PERM)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .cap_kind(kind),
    .cyc_done(cyc_done),
    .rev_o   (rev_flag),
    .perm_o  (perm_flag),
    .pend_o  (pend_flag)
  );

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rw,
  input logic       wp_pin,
  input logic [1:0] phase,
  input logic       cyc_done,
  input logic       ack_cmd,
  input logic       ack_addr,
  input logic       ack_data,
  input logic       ack_now,
  input logic       commit_ok,
  input logic       rev_flag,
  input logic       perm_flag,
  input logic       prot_cmd,
  input logic       pend_flag
);

  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    perm_flag |=> perm_flag); // R8

  AST_FLAGS_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_done |=> ($stable(rev_flag) && $stable(perm_flag))); // R7

  AST_NO_PEND_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_flag |=> ($stable(rev_flag) && $stable(perm_flag))); // R9

  AST_PIN_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wp_pin |-> !commit_ok); // R3

  AST_PERM_REFUSES_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_flag && prot_cmd) |-> !(ack_cmd || ack_addr || ack_data)); // R5

  AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rw |-> !(ack_addr || ack_data || commit_ok)); // R6

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00) |-> !ack_now); // R10

  AST_DATA_AFTER_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_data |-> (ack_cmd && ack_addr)); // R2

endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rw       (rw),
  .wp_pin   (wp_pin),
  .phase    (phase),
  .cyc_done (cyc_done),
  .ack_cmd  (ack_cmd),
  .ack_addr (ack_addr),
  .ack_data (ack_data),
  .ack_now  (ack_now),
  .commit_ok(commit_ok),
  .rev_flag (rev_flag),
  .perm_flag(perm_flag),
  .prot_cmd (prot_cmd),
  .pend_flag(pend_flag)
);

// File: tb/test_wp_guard.sv
`timescale 1ns/100ps
module test_wp_guard;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dev_code = 4'h0;
  logic [2:0] dev_field = 3'd0;
  logic [2:0] strap = 3'b101;
  logic       rw = 1'b0;
  logic [7:0] word_addr = 8'h00;
  logic       wp_pin = 1'b0;
  logic [1:0] phase = 2'b00;
  logic       cyc_done = 1'b0;
  logic       ack_cmd, ack_addr, ack_data, ack_now, commit_ok;

  int checks = 0;
  int errors = 0;
  bit b_rev = 0;
  bit b_perm = 0;

  always #2 clk = ~clk;

  wp_guard i_wp_guard (
    .clk(clk), .rst_n(rst_n), .dev_code(dev_code), .dev_field(dev_field),
    .strap(strap), .rw(rw), .word_addr(word_addr), .wp_pin(wp_pin),
    .phase(phase), .cyc_done(cyc_done), .ack_cmd(ack_cmd),
    .ack_addr(ack_addr), .ack_data(ack_data), .ack_now(ack_now),
    .commit_ok(commit_ok)
  );

  // Expected {cmd, addr, data, commit} from the requirements.
  function automatic logic [3:0] expect_of(logic [3:0] c, logic [2:0] f,
      logic r, logic w, logic [7:0] a, bit rv, bit pm);
    int op;
    bit deny;
    if (c == 4'b1010) begin
      if (f != strap) return 4'b0000;
      if (r) return 4'b1000;
      if (w || (a < 8'h80 && (rv || pm))) return 4'b1100;
      return 4'b1111;
    end
    if (c != 4'b0110) return 4'b0000;
    op = (f == 3'b001) ? 1 : (f == 3'b011) ? 2 : (f == strap) ? 3 : 0;
    if (op == 0) return 4'b0000;
    deny = pm || (op == 1 && rv);
    if (deny) return 4'b0000;
    if (r) return 4'b1000;
    return w ? 4'b1100 : 4'b1111;
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s code=%b field=%b rw=%b wp=%b addr=%h phase=%b: actual=%b expected=%b",
               req, dev_code, dev_field, rw, wp_pin, word_addr, phase, got, exp);
    end
  endtask

  task automatic drive(logic [3:0] c, logic [2:0] f, logic r, logic w, logic [7:0] a);
    @(negedge clk);
    dev_code = c; dev_field = f; rw = r; wp_pin = w; word_addr = a; phase = 2'b00;
    #1;
  endtask

  function automatic logic [3:0] outs();
    return {ack_cmd, ack_addr, ack_data, commit_ok};
  endfunction

  task automatic sweep();
    logic [3:0] codes [3] = '{4'b1010, 4'b0110, 4'b1111};
    string tag;
    for (int ci = 0; ci < 3; ci++)
      for (int f = 0; f < 8; f++)
        for (int r = 0; r < 2; r++)
          for (int w = 0; w < 2; w++)
            for (int h = 0; h < 2; h++) begin
              drive(codes[ci], 3'(f), 1'(r), 1'(w), h ? 8'h85 : 8'h05);
              if (expect_of(codes[ci], 3'(f), 1'(r), 1'(w), 8'h05, 0, 0) == 4'b0000) tag = "R1";
              else if (r == 1) tag = "R6";
              else if (b_perm) tag = "R5";
              else if (b_rev) tag = "R4";
              else if (w == 1) tag = "R3";
              else tag = "R2";
              check(tag, outs(), expect_of(codes[ci], 3'(f), 1'(r), 1'(w),
                                           h ? 8'h85 : 8'h05, b_rev, b_perm));
            end
  endtask

  // Present a write-form protect command on its data phase for one edge.
  task automatic capture_cmd(logic [2:0] f);
    @(negedge clk);
    dev_code = 4'b0110; dev_field = f; rw = 1'b0; wp_pin = 1'b0;
    word_addr = 8'h00; phase = 2'b11;
    @(negedge clk);
    phase = 2'b00;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
  endtask

  // Probe state through a low-half memory write with pin low.
  task automatic probe(string req, bit rv, bit pm);
    drive(4'b1010, strap, 1'b0, 1'b0, 8'h10);
    check(req, outs(), expect_of(4'b1010, strap, 1'b0, 1'b0, 8'h10, rv, pm));
    drive(4'b0110, 3'b001, 1'b0, 1'b0, 8'h00);
    check(req, outs(), expect_of(4'b0110, 3'b001, 1'b0, 1'b0, 8'h00, rv, pm));
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: unprotected (R9, R2)
    probe("R9", 0, 0);

    sweep();

    // R7: set reversible takes effect only after the done pulse
    capture_cmd(3'b001);
    probe("R7", 0, 0);
    pulse_done();
    b_rev = 1;
    probe("R7", 1, 0);
    sweep();

    // R9: reset drops a pending clear and keeps the flags
    capture_cmd(3'b011);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    pulse_done();
    probe("R9", 1, 0);

    // R7: clear reversible
    capture_cmd(3'b011);
    pulse_done();
    b_rev = 0;
    probe("R7", 0, 0);

    // R7: set reversible again, then permanent via strap field
    capture_cmd(3'b001);
    pulse_done();
    b_rev = 1;
    capture_cmd(strap);
    pulse_done();
    b_perm = 1;
    probe("R7", 1, 1);
    sweep();

    // R8: clear is refused and cannot undo the permanent flag, nor can reset
    capture_cmd(3'b011);
    pulse_done();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    probe("R8", 1, 1);
    drive(4'b0110, 3'b011, 1'b0, 1'b0, 8'h00);
    check("R8", outs(), 4'b0000);

    // R10: per-phase acknowledge, low-half write in permanent state (1,1,0)
    drive(4'b1010, strap, 1'b0, 1'b0, 8'h20);
    for (int p = 0; p < 4; p++) begin
      phase = 2'(p);
      #0.5;
      check("R10", {3'b000, ack_now}, {3'b000, (p == 1) || (p == 2)});
    end
    // R10: high-half write accepted on every phase
    phase = 2'b00;
    drive(4'b1010, strap, 1'b0, 1'b0, 8'hA0);
    for (int p = 0; p < 4; p++) begin
      phase = 2'(p);
      #0.5;
      check("R10", {3'b000, ack_now}, {3'b000, p != 0});
    end
    phase = 2'b00;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule